// File: doc/BRIEF.md
# Temporal Frame Memory Controller

The block sits in front of a spatio-temporal video filter. It writes each incoming pixel into an external single-port frame memory. For the same pixel it also returns the pixels at the same column and line from the `NLEV` frames that came before. The filter therefore sees the current pixel and its temporal neighbours as one aligned sample.

The external memory is split into `NLEV+1` frame-sized regions, and these are used as a ring. A fixed slot table runs one write and then `NLEV` reads for each pixel, back to back, on the one memory port. The memory port has synchronous read data, one cycle after the address, and it needs no dead cycle between a read and a write. The data that comes back goes into one small FIFO per temporal level, and a further FIFO holds the current pixel. A sample is released only when every FIFO holds an entry.

Top module: `temporal_frame_mem`

## Requirements
- R1: Each accepted pixel is written once, with `memWe` high, to address `region*IMG_W*IMG_H + line*IMG_W + col`, with `memWdata` equal to the pixel.
- R2: The first frame after reset is written to region 0. Every later `frameStart` moves the write region to the next one, modulo `NLEV+1`.
- R3: Output level k (slice `k-1` of `outPrev`, k = 1..NLEV) carries the pixel written at the same column and line in the region k positions behind the current write region.
- R4: Each pixel takes `NLEV+1` memory cycles. The write comes in the cycle after the pixel is accepted, and the reads for levels 1..NLEV follow in consecutive cycles. The caller must space `pixValid` pulses at least `NLEV+1` cycles apart.
- R5: Level k is flagged valid (`outPrevValid[k-1]`=1) only when at least k frame starts have been seen before the current frame since reset. An invalid level outputs all-zero data.
- R6: Each accepted pixel produces exactly one `outValid` pulse. The pulses come in input order, with `outPix` equal to the pixel, exactly `NLEV+3` rising edges after the accepting edge.
- R7: A pixel with `frameStart` high is placed at column 0, line 0. The column then advances per pixel and wraps into the next line after `IMG_W-1`, so a frame may end early.
- R8: While reset is held, `outValid` and `memWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Input pixel strobe |
| pixIn | input | PIX_W | Input pixel value |
| frameStart | input | 1 | Marks the first pixel of a frame |
| memAddr | output | clog2((NLEV+1)*IMG_W*IMG_H) | Frame memory address |
| memWdata | output | PIX_W | Frame memory write data |
| memWe | output | 1 | Frame memory write enable |
| memRdata | input | PIX_W | Frame memory read data, one cycle after the address |
| outValid | output | 1 | Aligned sample strobe |
| outPix | output | PIX_W | Current pixel |
| outPrev | output | NLEV*PIX_W | Older pixels; slice k-1 holds level k |
| outPrevValid | output | NLEV | Per-level validity |

## Verification
The assertions check on every cycle the shape of the slot schedule: a write is always followed by a non-write, and writes come at least `NLEV+1` cycles apart. They also check that the input keeps the same spacing and that the address stays inside the ring. On every output they check that the validity flags are ordered by age and that invalid levels are zero. The bench scenarios cover what needs history across frames: the ring rotation, the data returned from older frames after a frame that ends early, the growth of validity over the first frames, and the exact latency at full rate and with idle gaps.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  // Slot strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrSlot;     // write slot: current pixel goes to memory
    logic rdSlot;     // read slot: one older level is fetched
    logic firstRead;  // read slot of level 1
  } tfm_strobe_t;
endpackage

// File: rtl/tfm_fifo.sv
module tfm_fifo #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              notEmpty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W:0]    count;

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
    end
  end

  assign dout     = store[rdPtr];
  assign notEmpty = (count != '0);
endmodule

// File: rtl/tfm_ctrl.sv
module tfm_ctrl
  import tfm_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int IMG_W  = 8,
  parameter int IMG_H  = 4,
  parameter int NLEV   = 2,
  parameter int ADDR_W = 7,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic              frameStart,
  input  logic [PIX_W-1:0]  pixIn,
  output tfm_strobe_t       strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [PIX_W-1:0]  memWdata,
  output logic [NLEV-1:0]   ctxMask
);
  localparam int NFR         = NLEV + 1;
  localparam int FRAME_WORDS = IMG_W * IMG_H;
  localparam int SLOT_W      = $clog2(NFR);
  localparam int FRM_W       = $clog2(NFR);
  localparam int TMP_W       = FRM_W + 2;
  localparam int COL_W       = $clog2(IMG_W);
  localparam int LINE_W      = $clog2(IMG_H);
  // Compile-time slot pattern: bit s set means slot s is the write slot
  localparam logic [NLEV:0] WR_PATTERN = {{NLEV{1'b0}}, 1'b1};

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic [PIX_W-1:0]  ctxPix;
  logic [FRM_W-1:0]  ctxFrame, wrFrame, framesDone;
  logic [OFF_W-1:0]  ctxOff;
  logic [COL_W-1:0]  col;
  logic [LINE_W-1:0] line;
  logic              seenFrame;

  logic              accept, startNew, slotIsWrite;
  logic [FRM_W-1:0]  frameSel, doneSel, region;
  logic [COL_W-1:0]  colUse, colNext;
  logic [LINE_W-1:0] lineUse, lineNext;
  logic [OFF_W-1:0]  offSel;
  logic [NLEV-1:0]   maskSel;
  logic [TMP_W-1:0]  backTmp;

  always_comb begin
    accept   = pixValid && (!busy || slot == SLOT_W'(NLEV));
    startNew = frameStart && seenFrame;
    frameSel = wrFrame;
    if (startNew) frameSel = (wrFrame == FRM_W'(NLEV)) ? '0 : wrFrame + 1'b1;
    doneSel = framesDone;
    if (startNew && framesDone != FRM_W'(NLEV)) doneSel = framesDone + 1'b1;
    maskSel = '0;
    for (int k = 0; k < NLEV; k++) maskSel[k] = (int'(doneSel) > k);
    colUse  = frameStart ? '0 : col;
    lineUse = frameStart ? '0 : line;
    offSel  = OFF_W'(lineUse) * OFF_W'(IMG_W) + OFF_W'(colUse);
    if (colUse == COL_W'(IMG_W - 1)) begin
      colNext  = '0;
      lineNext = (lineUse == LINE_W'(IMG_H - 1)) ? '0 : lineUse + 1'b1;
    end else begin
      colNext  = colUse + 1'b1;
      lineNext = lineUse;
    end
  end

  // Slot decode and address formation
  always_comb begin
    slotIsWrite    = WR_PATTERN[slot];
    strb.wrSlot    = busy && slotIsWrite;
    strb.rdSlot    = busy && !slotIsWrite;
    strb.firstRead = busy && (slot == SLOT_W'(1));
    backTmp = TMP_W'(ctxFrame) + TMP_W'(NFR) - TMP_W'(slot);
    if (backTmp >= TMP_W'(NFR)) backTmp = backTmp - TMP_W'(NFR);
    region  = slotIsWrite ? ctxFrame : backTmp[FRM_W-1:0];
    memAddr = ADDR_W'(region) * ADDR_W'(FRAME_WORDS) + ADDR_W'(ctxOff);
  end

  assign memWe    = strb.wrSlot;
  assign memWdata = ctxPix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      slot       <= '0;
      ctxPix     <= '0;
      ctxFrame   <= '0;
      ctxOff     <= '0;
      ctxMask    <= '0;
      wrFrame    <= '0;
      framesDone <= '0;
      col        <= '0;
      line       <= '0;
      seenFrame  <= 1'b0;
    end else if (accept) begin
      busy       <= 1'b1;
      slot       <= '0;
      ctxPix     <= pixIn;
      ctxFrame   <= frameSel;
      ctxOff     <= offSel;
      ctxMask    <= maskSel;
      wrFrame    <= frameSel;
      framesDone <= doneSel;
      col        <= colNext;
      line       <= lineNext;
      seenFrame  <= 1'b1;
    end else if (busy) begin
      if (slot == SLOT_W'(NLEV)) busy <= 1'b0;
      else                       slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/tfm_datapath.sv
module tfm_datapath
  import tfm_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int NLEV       = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tfm_strobe_t           strb,
  input  logic [PIX_W-1:0]      ctxPix,
  input  logic [NLEV-1:0]       ctxMask,
  input  logic [PIX_W-1:0]      memRdata,
  output logic                  outValid,
  output logic [PIX_W-1:0]      outPix,
  output logic [NLEV*PIX_W-1:0] outPrev,
  output logic [NLEV-1:0]       outPrevValid
);
  localparam int LVL_W = (NLEV > 1) ? $clog2(NLEV) : 1;

  logic [NLEV-1:0]  maskHold;
  logic             retPend;
  logic [LVL_W-1:0] retLevel, lastLvl, issueLvl;
  logic             release_all;
  logic             curNotEmpty;
  logic [PIX_W-1:0] curDout;
  logic [NLEV-1:0]  levPush, levNotEmpty;
  logic [PIX_W:0]   levDin  [NLEV];
  logic [PIX_W:0]   levDout [NLEV];

  assign issueLvl = strb.firstRead ? '0 : lastLvl + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskHold <= '0;
      retPend  <= 1'b0;
      retLevel <= '0;
      lastLvl  <= '0;
    end else begin
      if (strb.wrSlot) maskHold <= ctxMask;
      retPend <= strb.rdSlot;
      if (strb.rdSlot) begin
        lastLvl  <= issueLvl;
        retLevel <= issueLvl;
      end
    end
  end

  tfm_fifo #(.DATA_W(PIX_W), .DEPTH(FIFO_DEPTH)) curFifo (
    .clk(clk), .rstN(rstN), .push(strb.wrSlot), .pop(release_all),
    .din(ctxPix), .dout(curDout), .notEmpty(curNotEmpty)
  );

  for (genvar k = 0; k < NLEV; k++) begin : g_level
    assign levPush[k] = retPend && (retLevel == LVL_W'(k));
    assign levDin[k]  = {maskHold[k], maskHold[k] ? memRdata : {PIX_W{1'b0}}};
    tfm_fifo #(.DATA_W(PIX_W + 1), .DEPTH(FIFO_DEPTH)) levFifo (
      .clk(clk), .rstN(rstN), .push(levPush[k]), .pop(release_all),
      .din(levDin[k]), .dout(levDout[k]), .notEmpty(levNotEmpty[k])
    );
  end

  assign release_all = curNotEmpty && (&levNotEmpty);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outPix       <= '0;
      outPrev      <= '0;
      outPrevValid <= '0;
    end else begin
      outValid <= release_all;
      if (release_all) begin
        outPix <= curDout;
        for (int k = 0; k < NLEV; k++) begin
          outPrev[k*PIX_W +: PIX_W] <= levDout[k][PIX_W-1:0];
          outPrevValid[k]           <= levDout[k][PIX_W];
        end
      end
    end
  end
endmodule

// File: rtl/temporal_frame_mem.sv
module temporal_frame_mem
  import tfm_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int IMG_W      = 8,
  parameter int IMG_H      = 4,
  parameter int NLEV       = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         pixValid,
  input  logic [PIX_W-1:0]                             pixIn,
  input  logic                                         frameStart,
  output logic [$clog2((NLEV+1)*IMG_W*IMG_H)-1:0]      memAddr,
  output logic [PIX_W-1:0]                             memWdata,
  output logic                                         memWe,
  input  logic [PIX_W-1:0]                             memRdata,
  output logic                                         outValid,
  output logic [PIX_W-1:0]                             outPix,
  output logic [NLEV*PIX_W-1:0]                        outPrev,
  output logic [NLEV-1:0]                              outPrevValid
);
  localparam int ADDR_W = $clog2((NLEV + 1) * IMG_W * IMG_H);
  localparam int OFF_W  = $clog2(IMG_W * IMG_H);

  tfm_strobe_t     strb;
  logic [NLEV-1:0] ctxMask;

  tfm_ctrl #(
    .PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .NLEV(NLEV),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
    .pixIn(pixIn), .strb(strb), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .ctxMask(ctxMask)
  );

  tfm_datapath #(
    .PIX_W(PIX_W), .NLEV(NLEV), .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ctxPix(memWdata), .ctxMask(ctxMask),
    .memRdata(memRdata), .outValid(outValid), .outPix(outPix),
    .outPrev(outPrev), .outPrevValid(outPrevValid)
  );
endmodule

// File: rtl/tfm_checker.sv
module tfm_checker #(
  parameter int PIX_W  = 8,
  parameter int IMG_W  = 8,
  parameter int IMG_H  = 4,
  parameter int NLEV   = 2,
  parameter int ADDR_W = 7
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  pixValid,
  input logic                  memWe,
  input logic [ADDR_W-1:0]     memAddr,
  input logic                  outValid,
  input logic [NLEV*PIX_W-1:0] outPrev,
  input logic [NLEV-1:0]       outPrevValid
);
  localparam int LIMIT = (NLEV + 1) * IMG_W * IMG_H;
  localparam int CNT_W = $clog2(NLEV + 2) + 1;

  logic [CNT_W-1:0] sinceWr, sincePix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceWr  <= CNT_W'(NLEV + 1);
      sincePix <= CNT_W'(NLEV + 1);
    end else begin
      if (memWe) sinceWr <= '0;
      else if (sinceWr != CNT_W'(NLEV + 1)) sinceWr <= sinceWr + 1'b1;
      if (pixValid) sincePix <= '0;
      else if (sincePix != CNT_W'(NLEV + 1)) sincePix <= sincePix + 1'b1;
    end
  end

  assert_write_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> sinceWr >= CNT_W'(NLEV));

  assert_read_follows_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  assert_input_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> sincePix >= CNT_W'(NLEV));

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> int'(memAddr) < LIMIT);

  for (genvar k = 0; k < NLEV; k++) begin : g_lvl
    assert_invalid_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !outPrevValid[k]) |-> outPrev[k*PIX_W +: PIX_W] == '0);
    if (k > 0) begin : g_ord
      assert_valid_order_R5: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outPrevValid[k]) |-> outPrevValid[k-1]);
    end
  end
endmodule

bind temporal_frame_mem tfm_checker #(
  .PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .NLEV(NLEV), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .memWe(memWe), .memAddr(memAddr),
  .outValid(outValid), .outPrev(outPrev), .outPrevValid(outPrevValid)
);

// File: tb/temporal_frame_mem_tb_top.sv
module temporal_frame_mem_tb_top;
  localparam int PW  = 8;
  localparam int W   = 8;
  localparam int H   = 4;
  localparam int NL  = 2;
  localparam int NFR = NL + 1;
  localparam int FW  = W * H;
  localparam int AW  = $clog2(NFR * FW);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          pixValid = 1'b0;
  logic [PW-1:0] pixIn = '0;
  logic          frameStart = 1'b0;
  logic [AW-1:0] memAddr;
  logic [PW-1:0] memWdata, memRdata;
  logic          memWe;
  logic          outValid;
  logic [PW-1:0] outPix;
  logic [NL*PW-1:0] outPrev;
  logic [NL-1:0]    outPrevValid;

  temporal_frame_mem #(.PIX_W(PW), .IMG_W(W), .IMG_H(H), .NLEV(NL)) dut_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixIn(pixIn),
    .frameStart(frameStart), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .outValid(outValid), .outPix(outPix),
    .outPrev(outPrev), .outPrevValid(outPrevValid)
  );

  function automatic int initVal(int i);
    return 8'h80 | (i & 8'h7f);
  endfunction

  // External memory model: synchronous read, write-enable port
  logic [PW-1:0] mem [NFR*FW];
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int qAddr[$], qWdata[$], qWcyc[$], qPix[$], qOcyc[$];
  logic [NL*PW-1:0] qPrev[$];
  logic [NL-1:0]    qPv[$];
  int shadow [NFR][FW];
  int frameNo = -1;
  int pos = 0;

  task automatic sendPix(int val, bit sof, int gap);
    logic [NL*PW-1:0] ep;
    logic [NL-1:0]    ev;
    int region;
    @(negedge clk);
    if (sof) begin frameNo++; pos = 0; end
    region = frameNo % NFR;
    qAddr.push_back(region * FW + pos);
    qWdata.push_back(val);
    qWcyc.push_back(cyc + 1);
    ep = '0; ev = '0;
    for (int k = 1; k <= NL; k++) begin
      if (frameNo >= k) begin
        ev[k-1] = 1'b1;
        ep[(k-1)*PW +: PW] = PW'(shadow[(frameNo - k) % NFR][pos]);
      end
    end
    qPix.push_back(val);
    qPrev.push_back(ep);
    qPv.push_back(ev);
    qOcyc.push_back(cyc + 1 + NL + 3);
    shadow[region][pos] = val;
    pos = (pos + 1) % FW;
    pixValid = 1'b1; pixIn = PW'(val); frameStart = sof;
    @(negedge clk);
    pixValid = 1'b0; frameStart = 1'b0;
    repeat (NL + gap) @(negedge clk);
  endtask

  task automatic sendFrame(int npix, int gapMode);
    for (int p = 0; p < npix; p++) begin
      int g;
      int v;
      g = (gapMode == 0) ? 0 : int'($urandom_range(0, 3));
      v = int'($urandom_range(0, 255));
      if (p == 1) v = 0;
      if (p == 2) v = 255;
      sendPix(v, p == 0, g);
    end
  endtask

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        if (qAddr.size() == 0) check(1'b0, "R1", "unexpected write", 1, 0);
        else begin
          int a, d, c;
          a = qAddr.pop_front(); d = qWdata.pop_front(); c = qWcyc.pop_front();
          check(int'(memAddr) == a, "R2", "write address", int'(memAddr), a);
          check(int'(memWdata) == d, "R1", "write data", int'(memWdata), d);
          check(cyc == c, "R4", "write slot cycle", cyc, c);
        end
      end
      if (outValid) begin
        if (qPix.size() == 0) check(1'b0, "R6", "unexpected output", 1, 0);
        else begin
          int ep, oc;
          logic [NL*PW-1:0] pv;
          logic [NL-1:0] vv;
          ep = qPix.pop_front(); pv = qPrev.pop_front();
          vv = qPv.pop_front(); oc = qOcyc.pop_front();
          check(int'(outPix) == ep, "R6", "current pixel", int'(outPix), ep);
          check(cyc == oc, "R6", "output latency", cyc, oc);
          for (int k = 0; k < NL; k++) begin
            check(outPrevValid[k] == vv[k], "R5", "level valid",
                  int'(outPrevValid[k]), int'(vv[k]));
            check(outPrev[k*PW +: PW] == pv[k*PW +: PW], "R3", "older pixel",
                  int'(outPrev[k*PW +: PW]), int'(pv[k*PW +: PW]));
          end
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NFR * FW; i++) begin
      mem[i] = PW'(initVal(i));
      shadow[i / FW][i % FW] = initVal(i);
    end
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid in reset", int'(outValid), 0);
    check(memWe == 1'b0, "R8", "memWe in reset", int'(memWe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    sendFrame(FW, 1);  // frame 0: no history, random gaps
    sendFrame(FW, 0);  // frame 1: full rate, level 1 only
    sendFrame(5, 1);   // frame 2: short frame, R7 restart of counters
    sendFrame(FW, 0);  // frame 3: ring wraps to region 0, R2
    sendFrame(FW, 1);  // frame 4: level 2 reads the short frame's region, R3
    sendFrame(FW, 0);  // frame 5
    repeat (20) @(negedge clk);
    check(qPix.size() == 0, "R6", "outputs pending", qPix.size(), 0);
    check(qAddr.size() == 0, "R1", "writes pending", qAddr.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule